// File: doc/BRIEF.md
# Banked Display-Window Address Mapper

This block turns a CPU access that falls inside a small legacy display window (at most 64 KB) into a linear address in a much larger video memory. The window is split into a lower and an upper 32 KB half, and each half is served by a bank. A bank's base comes from an 8-bit offset register scaled by a selectable granularity. In dual-bank mode each half has its own offset register. In single-bank mode both halves share the first offset register, and the upper half automatically sits 32 KB above the lower one.

Every bank carries a limit: the number of bytes left between its base and the end of installed memory. The block captures bases and limits in registers only when a bank offset or control register is written, using the installed-memory size present at that moment. An access is released to memory only when its in-bank offset lies below the selected bank's limit. The block also decodes the width of the write-mode field, which a neighbouring datapath uses.

Registers are written through a small indexed port. `wr_sel` picks the target: 0 is bank offset A, 1 is bank offset B, 2 is control and 3 is write mode. Control bit 0 selects dual-bank mode, bit 2 selects the extended write-mode field, and bit 5 selects coarse granularity. Only these control bits are kept.

Top module: `bankmap_top`

## Requirements
- R1: After reset, both bank limits are zero. `bank_ok` reads 00, `mem_en` stays low for every access, and `wmode` reads 0.
- R2: With control bit 0 clear, the lower half (address bit 15 = 0) maps to offset A scaled by the granularity, plus address bits [14:0].
- R3: With control bit 0 set, the upper half (bit 15 = 1) maps to offset B scaled by the granularity, plus address bits [14:0]. The lower half keeps using offset A.
- R4: The offset register is shifted left by 14 bits when control bit 5 is set, and by 12 bits when it is clear.
- R5: A bank's limit equals the installed size minus its scaled offset, or zero when the scaled offset is at or beyond the installed size. `mem_en` is high only when `cpu_req` is high and the in-bank offset is below the limit. `bank_ok[i]` is high exactly when bank i's limit is nonzero.
- R6: In single-bank mode the upper bank's base is offset A scaled plus 0x8000, and its limit is the lower limit minus 0x8000. This applies only when the lower limit is strictly greater than 0x8000. Otherwise the upper bank's limit is zero.
- R7: A bank whose limit is zero has a base of zero. An access through it yields `lin_addr` equal to address bits [14:0].
- R8: `cpu_addr` is ANDed with `win_mask` before bit 15 selects the bank and bits [14:0] form the in-bank offset.
- R9: When `cpu_req` is low, `mem_en` is low.
- R10: Bases and limits are recomputed only on the clock edge that writes register 0, 1 or 2. A change of `mem_size` alone, or a write to register 3, leaves `lin_addr`, `mem_en` and `bank_ok` unchanged.
- R11: `wmode` equals write-mode register bits [2:0] when control bit 2 is set. When it is clear, `wmode` is {0, bits [1:0]}. It changes only on writes to register 2 or 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register index: 0 offset A, 1 offset B, 2 control, 3 write mode |
| wr_data | input | 8 | Register write data |
| mem_size | input | LIN_W (24) | Installed video memory size in bytes |
| win_mask | input | 16 | Mask applied to the window address |
| cpu_req | input | 1 | CPU access request |
| cpu_addr | input | 16 | Address within the display window |
| lin_addr | output | LIN_W (24) | Linear video-memory address |
| mem_en | output | 1 | Access is within the bank limit and may reach memory |
| bank_ok | output | 2 | Per-bank nonzero-limit flags |
| wmode | output | 3 | Decoded write-mode field |

## Verification
Directed accesses cover single-bank mode at both granularities, which distinguishes shared-offset mapping from the automatic upper-half step. Dual-bank writes show that each half follows its own register. Installed sizes are chosen so that a bank limit lands exactly on 0x8000, at zero, and on a small value. These cases separate a strict comparison from a non-strict one in the upper-half rule and in the in-bank check, and they confirm that a bank with zero limit collapses its base. Masked addresses show that bank selection happens after masking. Changes of `mem_size` without a register write, and writes to the write-mode register, confirm that captured limits stay stale until a relevant write. Random writes and accesses under a fixed seed then mix all modes against a bench model.

// File: rtl/bankmap_pkg.sv
package bankmap_pkg;
  // control bit positions
  localparam int CTL_DUAL_BIT   = 0;
  localparam int CTL_XWM_BIT    = 2;
  localparam int CTL_COARSE_BIT = 5;

  // granularity shifts and window geometry
  localparam int FINE_SHIFT   = 12;
  localparam int COARSE_SHIFT = 14;
  localparam int HALF_BITS    = 15;
  localparam int WIN_W        = HALF_BITS + 1;
  localparam int HALF_SPAN    = 1 << HALF_BITS;
  localparam int NUM_BANKS    = 2;
  localparam int WM_W         = 3;

  typedef enum logic [1:0] {
    SEL_OFS_A = 2'd0,
    SEL_OFS_B = 2'd1,
    SEL_CTRL  = 2'd2,
    SEL_MODE  = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic coarse;
    logic xwm;
    logic dual;
  } ctrl_t;
endpackage

// File: rtl/bankmap_rst_sync.sv
module bankmap_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/bankmap_regs.sv
module bankmap_regs
  import bankmap_pkg::*;
#(
  parameter int OFS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [OFS_W-1:0] wr_data,
  output logic [OFS_W-1:0] ofs_a_d,
  output logic [OFS_W-1:0] ofs_b_d,
  output ctrl_t            ctrl_d,
  output ctrl_t            ctrl_q,
  output logic [WM_W-1:0]  mode_q,
  output logic             recalc
);
  reg_sel_e          sel;
  logic [OFS_W-1:0]  ofs_a_q;
  logic [OFS_W-1:0]  ofs_b_q;
  logic [WM_W-1:0]   mode_d;
  logic              en_a;
  logic              en_b;
  logic              en_c;
  logic              en_m;

  assign sel  = reg_sel_e'(wr_sel);
  assign en_a = wr_en && (sel == SEL_OFS_A);
  assign en_b = wr_en && (sel == SEL_OFS_B);
  assign en_c = wr_en && (sel == SEL_CTRL);
  assign en_m = wr_en && (sel == SEL_MODE);

  // next-state: values visible on the edge that commits the write
  always_comb begin
    ofs_a_d = en_a ? wr_data : ofs_a_q;
    ofs_b_d = en_b ? wr_data : ofs_b_q;
    ctrl_d  = ctrl_q;
    if (en_c) begin
      ctrl_d.dual   = wr_data[CTL_DUAL_BIT];
      ctrl_d.xwm    = wr_data[CTL_XWM_BIT];
      ctrl_d.coarse = wr_data[CTL_COARSE_BIT];
    end
    mode_d = en_m ? wr_data[WM_W-1:0] : mode_q;
  end

  assign recalc = en_a || en_b || en_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ofs_a_q <= '0;
      ofs_b_q <= '0;
      ctrl_q  <= '0;
      mode_q  <= '0;
    end else begin
      if (en_a) ofs_a_q <= ofs_a_d;
      if (en_b) ofs_b_q <= ofs_b_d;
      if (en_c) ctrl_q  <= ctrl_d;
      if (en_m) mode_q  <= mode_d;
    end
  end
endmodule

// File: rtl/bankmap_bank_calc.sv
module bankmap_bank_calc
  import bankmap_pkg::*;
#(
  parameter int OFS_W = 8,
  parameter int LIN_W = 24,
  parameter bit UPPER = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [OFS_W-1:0] ofs_raw,
  input  logic             coarse,
  input  logic             dual,
  input  logic [LIN_W-1:0] mem_size,
  output logic [LIN_W-1:0] base_q,
  output logic [LIN_W-1:0] lim_q
);
  localparam logic [LIN_W-1:0] HALF = LIN_W'(HALF_SPAN);

  logic             split;
  logic [LIN_W-1:0] ofs_sh;
  logic [LIN_W-1:0] lim_raw;
  logic [LIN_W-1:0] base_d;
  logic [LIN_W-1:0] lim_d;

  // only the upper bank steps by half a window in single-bank mode
  generate
    if (UPPER) begin : g_upper
      assign split = !dual;
    end else begin : g_lower
      logic unused_dual;
      assign unused_dual = dual;
      assign split = 1'b0;
    end
  endgenerate

  always_comb begin
    ofs_sh  = coarse ? (LIN_W'(ofs_raw) << COARSE_SHIFT)
                     : (LIN_W'(ofs_raw) << FINE_SHIFT);
    lim_raw = (mem_size <= ofs_sh) ? '0 : (mem_size - ofs_sh);
    base_d  = ofs_sh;
    lim_d   = lim_raw;
    if (split) begin
      if (lim_raw > HALF) begin
        base_d = ofs_sh + HALF;
        lim_d  = lim_raw - HALF;
      end else begin
        lim_d  = '0;
      end
    end
    if (lim_d == '0) begin
      base_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      lim_q  <= '0;
    end else if (load) begin
      base_q <= base_d;
      lim_q  <= lim_d;
    end
  end
endmodule

// File: rtl/bankmap_xlate.sv
module bankmap_xlate
  import bankmap_pkg::*;
#(
  parameter int LIN_W = 24
) (
  input  logic             cpu_req,
  input  logic [WIN_W-1:0] cpu_addr,
  input  logic [WIN_W-1:0] win_mask,
  input  logic [LIN_W-1:0] base0,
  input  logic [LIN_W-1:0] base1,
  input  logic [LIN_W-1:0] lim0,
  input  logic [LIN_W-1:0] lim1,
  output logic [LIN_W-1:0] lin_addr,
  output logic             mem_en
);
  logic [WIN_W-1:0]     masked;
  logic                 hi_half;
  logic [HALF_BITS-1:0] in_ofs;
  logic [LIN_W-1:0]     in_ofs_w;
  logic [LIN_W-1:0]     base_s;
  logic [LIN_W-1:0]     lim_s;

  always_comb begin
    masked   = cpu_addr & win_mask;
    hi_half  = masked[HALF_BITS];
    in_ofs   = masked[HALF_BITS-1:0];
    in_ofs_w = LIN_W'(in_ofs);
    base_s   = hi_half ? base1 : base0;
    lim_s    = hi_half ? lim1  : lim0;
    lin_addr = base_s + in_ofs_w;
    mem_en   = cpu_req && (in_ofs_w < lim_s);
  end
endmodule

// File: rtl/bankmap_top.sv
module bankmap_top
  import bankmap_pkg::*;
#(
  parameter int OFS_W = 8,
  localparam int LIN_W = OFS_W + COARSE_SHIFT + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [OFS_W-1:0] wr_data,
  input  logic [LIN_W-1:0] mem_size,
  input  logic [WIN_W-1:0] win_mask,
  input  logic             cpu_req,
  input  logic [WIN_W-1:0] cpu_addr,
  output logic [LIN_W-1:0] lin_addr,
  output logic             mem_en,
  output logic [NUM_BANKS-1:0] bank_ok,
  output logic [WM_W-1:0]  wmode
);
  logic             rst_n_i;
  logic [OFS_W-1:0] ofs_a_d;
  logic [OFS_W-1:0] ofs_b_d;
  ctrl_t            ctrl_d;
  ctrl_t            ctrl_q;
  logic [WM_W-1:0]  mode_q;
  logic             recalc;
  logic [LIN_W-1:0] base_q [NUM_BANKS];
  logic [LIN_W-1:0] lim_q  [NUM_BANKS];

  bankmap_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  bankmap_regs #(.OFS_W(OFS_W)) i_regs (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .ofs_a_d (ofs_a_d),
    .ofs_b_d (ofs_b_d),
    .ctrl_d  (ctrl_d),
    .ctrl_q  (ctrl_q),
    .mode_q  (mode_q),
    .recalc  (recalc)
  );

  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic [OFS_W-1:0] ofs_pick;
      assign ofs_pick = (b == 1 && ctrl_d.dual) ? ofs_b_d : ofs_a_d;

      bankmap_bank_calc #(
        .OFS_W (OFS_W),
        .LIN_W (LIN_W),
        .UPPER (b == 1)
      ) i_calc (
        .clk      (clk),
        .rst_n    (rst_n_i),
        .load     (recalc),
        .ofs_raw  (ofs_pick),
        .coarse   (ctrl_d.coarse),
        .dual     (ctrl_d.dual),
        .mem_size (mem_size),
        .base_q   (base_q[b]),
        .lim_q    (lim_q[b])
      );

      assign bank_ok[b] = (lim_q[b] != '0);
    end
  endgenerate

  bankmap_xlate #(.LIN_W(LIN_W)) i_xlate (
    .cpu_req  (cpu_req),
    .cpu_addr (cpu_addr),
    .win_mask (win_mask),
    .base0    (base_q[0]),
    .base1    (base_q[1]),
    .lim0     (lim_q[0]),
    .lim1     (lim_q[1]),
    .lin_addr (lin_addr),
    .mem_en   (mem_en)
  );

  // write-mode field width follows the extended-mode control flag
  assign wmode = ctrl_q.xwm ? mode_q : {1'b0, mode_q[1:0]};

  logic unused_ctrl;
  assign unused_ctrl = ctrl_q.dual ^ ctrl_q.coarse;
endmodule

// File: rtl/bankmap_checker.sv
module bankmap_checker
  import bankmap_pkg::*;
#(
  parameter int LIN_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [1:0]       wr_sel,
  input logic             cpu_req,
  input logic [WIN_W-1:0] cpu_addr,
  input logic [WIN_W-1:0] win_mask,
  input logic [LIN_W-1:0] lin_addr,
  input logic             mem_en,
  input logic [NUM_BANKS-1:0] bank_ok,
  input logic [WM_W-1:0]  wmode
);
  logic [WIN_W-1:0] chk_masked;
  logic             chk_hi;
  logic [LIN_W-1:0] chk_ofs;

  assign chk_masked = cpu_addr & win_mask;
  assign chk_hi     = chk_masked[HALF_BITS];
  assign chk_ofs    = LIN_W'(chk_masked[HALF_BITS-1:0]);

  // R9: no memory enable without a request
  assert_no_req_no_en_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_req |-> !mem_en);

  // R5: an enabled access always goes through a bank with a nonzero limit
  assert_en_needs_bank_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> bank_ok[chk_hi]);

  // R7: a collapsed bank leaves only the in-bank offset
  assert_dead_bank_base_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !bank_ok[chk_hi] |-> (lin_addr == chk_ofs));

  // R10: limits hold unless an offset or control register is written
  assert_limits_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en || wr_sel == 2'd3) |=> $stable(bank_ok));

  // R11: write-mode output moves only on control or mode writes
  assert_wmode_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en || wr_sel == 2'd0 || wr_sel == 2'd1) |=> $stable(wmode));
endmodule

bind bankmap_top bankmap_checker #(.LIN_W(LIN_W)) i_bankmap_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .wr_sel   (wr_sel),
  .cpu_req  (cpu_req),
  .cpu_addr (cpu_addr),
  .win_mask (win_mask),
  .lin_addr (lin_addr),
  .mem_en   (mem_en),
  .bank_ok  (bank_ok),
  .wmode    (wmode)
);

// File: tb/test_bankmap_top.sv
`timescale 1ns/1ps
module test_bankmap_top;
  localparam int LW = 24;

  logic          clk;
  logic          rst_n;
  logic          wr_en;
  logic [1:0]    wr_sel;
  logic [7:0]    wr_data;
  logic [LW-1:0] mem_size;
  logic [15:0]   win_mask;
  logic          cpu_req;
  logic [15:0]   cpu_addr;
  logic [LW-1:0] lin_addr;
  logic          mem_en;
  logic [1:0]    bank_ok;
  logic [2:0]    wmode;

  int n_checks;
  int n_errors;
  bit done;

  // bench model
  logic [7:0]    m_a, m_b, m_ctl, m_mode;
  logic [LW-1:0] m_base [2];
  logic [LW-1:0] m_lim  [2];

  bankmap_top i_bankmap_top (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .mem_size(mem_size), .win_mask(win_mask), .cpu_req(cpu_req), .cpu_addr(cpu_addr),
    .lin_addr(lin_addr), .mem_en(mem_en), .bank_ok(bank_ok), .wmode(wmode)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [2*LW-1:0] calc_bank(input int b, input logic [7:0] ra,
      input logic [7:0] rb, input logic [7:0] ctl, input logic [LW-1:0] msz);
    logic [LW-1:0] o, l;
    logic [7:0] raw;
    raw = (ctl[0] && b == 1) ? rb : ra;
    o = LW'(raw) << (ctl[5] ? 14 : 12);
    l = (msz <= o) ? '0 : msz - o;
    if (!ctl[0] && b == 1) begin
      if (l > 24'h8000) begin
        o = o + 24'h8000;
        l = l - 24'h8000;
      end else begin
        l = '0;
      end
    end
    if (l == '0) o = '0;
    return {o, l};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [1:0] sel, input logic [7:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
    case (sel)
      2'd0: m_a = data;
      2'd1: m_b = data;
      2'd2: m_ctl = data;
      default: m_mode = data;
    endcase
    if (sel != 2'd3) begin
      for (int b = 0; b < 2; b++) begin
        logic [2*LW-1:0] r;
        r = calc_bank(b, m_a, m_b, m_ctl, mem_size);
        m_base[b] = r[2*LW-1:LW];
        m_lim[b]  = r[LW-1:0];
      end
    end
  endtask

  task automatic access(input string req, input logic rq, input logic [15:0] a);
    logic [15:0] mk;
    logic [LW-1:0] o;
    logic h;
    @(negedge clk);
    cpu_req = rq; cpu_addr = a;
    #2;
    mk = a & win_mask;
    h = mk[15];
    o = LW'(mk[14:0]);
    check({req, " lin_addr"}, 32'(lin_addr), 32'(m_base[h] + o));
    check({req, " mem_en"}, 32'(mem_en), 32'(rq && (o < m_lim[h])));
    check({req, " bank_ok"}, 32'(bank_ok), {30'b0, m_lim[1] != '0, m_lim[0] != '0});
    check({req, " wmode"}, 32'(wmode),
          32'(m_ctl[2] ? m_mode[2:0] : {1'b0, m_mode[1:0]}));
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    logic [LW-1:0] sizes [4];
    void'($urandom(32'd4711));
    n_checks = 0; n_errors = 0; done = 0;
    m_a = 0; m_b = 0; m_ctl = 0; m_mode = 0;
    m_base[0] = 0; m_base[1] = 0; m_lim[0] = 0; m_lim[1] = 0;
    rst_n = 0; wr_en = 0; wr_sel = 0; wr_data = 0;
    mem_size = 24'h200000; win_mask = 16'hFFFF; cpu_req = 0; cpu_addr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    access("R1", 1'b1, 16'h0000);
    access("R1", 1'b1, 16'h8123);

    // R2 single bank, fine granularity
    do_write(2'd2, 8'h00);
    do_write(2'd0, 8'h10);
    access("R2", 1'b1, 16'h0123);
    check("R2 base", 32'(lin_addr), 32'h10123);
    // R6 upper half steps by 0x8000
    access("R6", 1'b1, 16'h8010);
    check("R6 upper", 32'(lin_addr), 32'h18010);

    // R3/R4 dual, coarse
    do_write(2'd2, 8'h21);
    do_write(2'd1, 8'h03);
    access("R3", 1'b1, 16'h8004);
    check("R3 bank B", 32'(lin_addr), 32'h0C004);
    access("R4", 1'b1, 16'h0004);
    check("R4 coarse", 32'(lin_addr), 32'h40004);

    // R5 limits: mem 0x48000, dual fine
    mem_size = 24'h48000;
    do_write(2'd2, 8'h01);
    do_write(2'd0, 8'h46);
    access("R5", 1'b1, 16'h1FFF);
    check("R5 last byte", 32'(mem_en), 32'd1);
    access("R5", 1'b1, 16'h2000);
    check("R5 past limit", 32'(mem_en), 32'd0);
    do_write(2'd1, 8'h48);
    access("R5", 1'b1, 16'h8000);
    check("R5 bank off", 32'(bank_ok[1]), 32'd0);
    // R7 collapsed base
    access("R7", 1'b1, 16'h8155);
    check("R7 zero base", 32'(lin_addr), 32'h0155);

    // R6 boundary: limit exactly 0x8000 disables upper bank
    do_write(2'd2, 8'h00);
    do_write(2'd0, 8'h40);
    access("R6", 1'b1, 16'h8001);
    check("R6 exact half", 32'(bank_ok), 32'd1);
    do_write(2'd0, 8'h3F);
    access("R6", 1'b1, 16'h8FFF);
    check("R6 small upper", 32'(mem_en), 32'd1);
    access("R6", 1'b1, 16'h9000);

    // R8 mask removes bank select bit
    win_mask = 16'h7FFF;
    access("R8", 1'b1, 16'h8005);
    check("R8 masked", 32'(lin_addr), 32'h3F005);
    win_mask = 16'hFFFF;

    // R9 no request
    access("R9", 1'b0, 16'h0001);

    // R10 stale limits after size change and mode write
    mem_size = 24'h400000;
    @(negedge clk);
    access("R10", 1'b1, 16'h8FFF);
    access("R10", 1'b1, 16'h9000);
    do_write(2'd3, 8'h05);
    access("R10", 1'b1, 16'h9000);
    check("R10 still stale", 32'(mem_en), 32'd0);
    do_write(2'd2, 8'h00);
    access("R10", 1'b1, 16'h9000);
    check("R10 refreshed", 32'(mem_en), 32'd1);

    // R11 write-mode width
    do_write(2'd3, 8'h07);
    access("R11", 1'b1, 16'h0000);
    check("R11 narrow", 32'(wmode), 32'd3);
    do_write(2'd2, 8'h04);
    access("R11", 1'b1, 16'h0000);
    check("R11 wide", 32'(wmode), 32'd7);

    // random mix
    sizes[0] = 24'h40000; sizes[1] = 24'h100000; sizes[2] = 24'h200000; sizes[3] = 24'h400000;
    for (int i = 0; i < 400; i++) begin
      int pick;
      pick = $urandom_range(0, 9);
      if (pick < 2) begin
        mem_size = ($urandom_range(0, 1) == 0) ? sizes[$urandom_range(0, 3)]
                                                : LW'($urandom_range(0, 24'h400000));
      end else if (pick < 6) begin
        do_write(2'($urandom_range(0, 3)), 8'($urandom));
      end
      win_mask = ($urandom_range(0, 3) == 0) ? 16'h7FFF : 16'hFFFF;
      access("R5 random", 1'($urandom_range(0, 7) != 0), 16'($urandom));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule